// File: doc/BRIEF.md
# SPI Transfer Sequencer

This block is the controller side of a serial peripheral link. It runs a message made of transfer descriptors, one after the other. Each descriptor carries a byte count, separate enables for the outgoing and incoming directions, a wait in microseconds that follows the last bit, a flag that drops chip select once the transfer and its wait are over, and a flag that marks the end of the message. A descriptor may enable both directions (full duplex), only one of them (half duplex), or carry a byte count of zero, so that its wait is its only effect.

Outgoing bytes arrive on a ready/valid byte stream. Incoming bytes leave on another one, held in a single register. The block drives the serial clock, the serial data output and an active-low chip select. Clock polarity and phase are fixed by a parameter. The serial clock half-period is a parameter counted in system clocks, and a second parameter sets the number of system clocks in one microsecond.

Top module: `spi_seq_master`

## Requirements
- R1: After reset, cs_n is 1, sclk sits at the idle level, busy and rx_valid are 0, desc_ready is 1 and tx_ready is 0.
- R2: The parameter MODE is {CPOL, CPHA}. Bytes leave on mosi most significant bit first. With CPHA=1, data changes on the leading sclk edge and is sampled on the trailing edge. With CPHA=0, the first bit is set up before the leading edge and sampling happens on the leading edge. Every sampled miso byte of a receiving transfer is delivered on rx_data, in order.
- R3: With desc_tx_en=0, every bit sent on mosi is 1 (byte 0xFF). tx_ready stays 0, whatever tx_valid does.
- R4: With desc_rx_en=0, no byte is pushed to the receive stream.
- R5: A transfer with desc_len=0 makes no sclk edge. It holds chip select for its wait only.
- R6: After the last sclk edge of a transfer, cs_n stays low for at least desc_delay_us × CLKS_PER_US system clocks, and for no more than 6 clocks beyond that.
- R7: With desc_cs_change=1 on a transfer that is not the last, cs_n goes high after the wait. It stays high for at least 2 × HALF_CLKS clocks before the next descriptor asserts it again.
- R8: After the wait of the descriptor with desc_last=1, cs_n rises in the same cycle that busy falls. busy is high from the acceptance of the first descriptor of the message until then.
- R9: Between transfers of a message that carry desc_cs_change=0, cs_n stays low.
- R10: If a byte must be sent and tx_valid is 0, no sclk edge occurs and sclk stays idle until the byte arrives. The delayed byte is then sent unchanged.
- R11: sclk is at the idle level whenever cs_n is high. Each sclk edge is HALF_CLKS clocks after the previous one within a byte, and each byte takes exactly 16 edges.
- R12: While rx_valid is 1 and rx_ready is 0, rx_valid and rx_data hold. No further byte of a receiving transfer is shifted until the pending byte is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| desc_valid | input | 1 | Descriptor offered |
| desc_ready | output | 1 | Descriptor can be taken |
| desc_len | input | LEN_W | Byte count, may be 0 |
| desc_tx_en | input | 1 | Take outgoing bytes from the tx stream |
| desc_rx_en | input | 1 | Push incoming bytes to the rx stream |
| desc_delay_us | input | DLY_W | Wait after the last bit, in microseconds |
| desc_cs_change | input | 1 | Release chip select after this transfer |
| desc_last | input | 1 | Final descriptor of the message |
| tx_data | input | 8 | Outgoing byte |
| tx_valid | input | 1 | Outgoing byte available |
| tx_ready | output | 1 | Outgoing byte taken this cycle if valid |
| rx_data | output | 8 | Incoming byte |
| rx_valid | output | 1 | Incoming byte available |
| rx_ready | input | 1 | Consumer takes the incoming byte |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the peripheral |
| miso | input | 1 | Serial data from the peripheral |
| cs_n | output | 1 | Chip select, active low |
| busy | output | 1 | Message in progress |

## Verification
Some rules are checked by assertions on every cycle. The serial clock must sit at its idle level whenever chip select is high and while the sequencer waits for a byte. A held receive byte must stay stable under backpressure. The fall of busy must coincide with the release of chip select, and outgoing bytes may only be pulled while selected and enabled. Other behaviour shows only in the bench's scenarios, which use a peripheral model on the wires: the bit order and sampling edge, the 0xFF filler, the length of each wait and of the inter-transfer gap, the count of chip-select assertions across a multi-transfer message, and the exact bytes seen on both sides.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_CHECK,
        ST_SHIFT,
        ST_DELAY,
        ST_END,
        ST_GAP
    } seq_state_e;

endpackage

// File: rtl/spi_seq_divider.sv
module spi_seq_divider #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic tick_o
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick_o = run_i && (cnt_q == LAST);
        if (!run_i || tick_o) cnt_d = '0;
        else                  cnt_d = cnt_q + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // A tick may only come from a counter that was running in the previous cycle.
    assert_tick_run_R11: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |-> (DIV == 1 || $past(run_i)));
endmodule

// File: rtl/spi_seq_shifter.sv
module spi_seq_shifter #(
    parameter bit CPOL = 1'b0,
    parameter bit CPHA = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic [7:0] tx_byte_i,
    input  logic       half_tick_i,
    input  logic       miso_i,
    output logic       sclk_o,
    output logic       mosi_o,
    output logic [7:0] rx_byte_o,
    output logic       done_o
);
    localparam int EDGES = 16;
    localparam logic [3:0] LAST_EDGE = 4'(EDGES - 1);

    typedef struct packed {
        logic       active;
        logic [3:0] edge_no;
        logic       sclk;
        logic       out;
        logic [7:0] txsh;
        logic [7:0] rxsh;
        logic       done;
    } shf_regs_t;

    shf_regs_t r_d, r_q;
    logic leading;
    logic sample_now;

    always_comb begin
        r_d        = r_q;
        r_d.done   = 1'b0;
        leading    = ~r_q.edge_no[0];
        sample_now = (leading == ~CPHA);
        if (start_i) begin
            r_d.active  = 1'b1;
            r_d.edge_no = '0;
            r_d.sclk    = CPOL;
            r_d.rxsh    = '0;
            if (!CPHA) begin
                r_d.out  = tx_byte_i[7];
                r_d.txsh = {tx_byte_i[6:0], 1'b0};
            end else begin
                r_d.txsh = tx_byte_i;
            end
        end else if (r_q.active && half_tick_i) begin
            r_d.sclk = ~r_q.sclk;
            if (sample_now) begin
                r_d.rxsh = {r_q.rxsh[6:0], miso_i};
            end else if (CPHA || (r_q.edge_no != LAST_EDGE)) begin
                r_d.out  = r_q.txsh[7];
                r_d.txsh = {r_q.txsh[6:0], 1'b0};
            end
            if (r_q.edge_no == LAST_EDGE) begin
                r_d.active = 1'b0;
                r_d.done   = 1'b1;
            end else begin
                r_d.edge_no = r_q.edge_no + 4'd1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.sclk <= CPOL;
            r_q.out  <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign sclk_o    = r_q.sclk;
    assign mosi_o    = r_q.out;
    assign rx_byte_o = r_q.rxsh;
    assign done_o    = r_q.done;

    // R11: a finished byte has returned the clock to its idle level.
    assert_done_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.done |-> (sclk_o == CPOL));
    // R10: with no byte in flight and none starting, the clock does not move.
    assert_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!r_q.active && !start_i) |=> $stable(sclk_o));
endmodule

// File: rtl/spi_seq_master.sv
module spi_seq_master
    import spi_seq_pkg::*;
#(
    parameter logic [1:0] MODE        = 2'b00,
    parameter int         HALF_CLKS   = 4,
    parameter int         CLKS_PER_US = 100,
    parameter int         LEN_W       = 8,
    parameter int         DLY_W       = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             desc_valid,
    output logic             desc_ready,
    input  logic [LEN_W-1:0] desc_len,
    input  logic             desc_tx_en,
    input  logic             desc_rx_en,
    input  logic [DLY_W-1:0] desc_delay_us,
    input  logic             desc_cs_change,
    input  logic             desc_last,
    input  logic [7:0]       tx_data,
    input  logic             tx_valid,
    output logic             tx_ready,
    output logic [7:0]       rx_data,
    output logic             rx_valid,
    input  logic             rx_ready,
    output logic             sclk,
    output logic             mosi,
    input  logic             miso,
    output logic             cs_n,
    output logic             busy
);
    localparam bit CPOL = MODE[1];
    localparam bit CPHA = MODE[0];

    typedef struct packed {
        seq_state_e       state;
        logic [LEN_W-1:0] len;
        logic             tx_en;
        logic             rx_en;
        logic [DLY_W-1:0] dly;
        logic             cs_change;
        logic             last;
        logic             cs_on;
        logic             busy;
        logic             rx_valid;
        logic [7:0]       rx_data;
        logic             gap_half;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    logic       half_run, half_tick;
    logic       us_run, us_tick;
    logic       rx_block, check_go, byte_go;
    logic       eng_done;
    logic [7:0] eng_rx;
    logic [7:0] eng_tx;

    spi_seq_divider #(.DIV(HALF_CLKS)) u_half_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (half_run),
        .tick_o (half_tick)
    );

    spi_seq_divider #(.DIV(CLKS_PER_US)) u_us_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (us_run),
        .tick_o (us_tick)
    );

    spi_seq_shifter #(.CPOL(CPOL), .CPHA(CPHA)) u_shifter (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (byte_go),
        .tx_byte_i   (eng_tx),
        .half_tick_i (half_tick),
        .miso_i      (miso),
        .sclk_o      (sclk),
        .mosi_o      (mosi),
        .rx_byte_o   (eng_rx),
        .done_o      (eng_done)
    );

    always_comb begin
        r_d        = r_q;
        desc_ready = (r_q.state == ST_IDLE) || (r_q.state == ST_WAIT);
        rx_block   = r_q.rx_en && r_q.rx_valid;
        check_go   = (r_q.state == ST_CHECK) && (r_q.len != '0) && !rx_block;
        tx_ready   = check_go && r_q.tx_en;
        byte_go    = check_go && (!r_q.tx_en || tx_valid);
        eng_tx     = r_q.tx_en ? tx_data : 8'hFF;
        half_run   = (r_q.state == ST_SHIFT) || (r_q.state == ST_GAP);
        us_run     = (r_q.state == ST_DELAY);

        if (r_q.rx_valid && rx_ready) r_d.rx_valid = 1'b0;

        case (r_q.state)
            ST_IDLE, ST_WAIT: begin
                if (desc_valid) begin
                    r_d.len       = desc_len;
                    r_d.tx_en     = desc_tx_en;
                    r_d.rx_en     = desc_rx_en;
                    r_d.dly       = desc_delay_us;
                    r_d.cs_change = desc_cs_change;
                    r_d.last      = desc_last;
                    r_d.cs_on     = 1'b1;
                    r_d.busy      = 1'b1;
                    r_d.state     = ST_CHECK;
                end
            end
            ST_CHECK: begin
                if (r_q.len == '0) r_d.state = ST_DELAY;
                else if (byte_go)  r_d.state = ST_SHIFT;
            end
            ST_SHIFT: begin
                if (eng_done) begin
                    r_d.len = r_q.len - LEN_W'(1);
                    if (r_q.rx_en) begin
                        r_d.rx_valid = 1'b1;
                        r_d.rx_data  = eng_rx;
                    end
                    r_d.state = ST_CHECK;
                end
            end
            ST_DELAY: begin
                if (r_q.dly == '0) r_d.state = ST_END;
                else if (us_tick)  r_d.dly   = r_q.dly - DLY_W'(1);
            end
            ST_END: begin
                if (r_q.last) begin
                    r_d.cs_on = 1'b0;
                    r_d.busy  = 1'b0;
                    r_d.state = ST_IDLE;
                end else if (r_q.cs_change) begin
                    r_d.cs_on    = 1'b0;
                    r_d.gap_half = 1'b0;
                    r_d.state    = ST_GAP;
                end else begin
                    r_d.state = ST_WAIT;
                end
            end
            ST_GAP: begin
                if (half_tick) begin
                    if (r_q.gap_half) r_d.state    = ST_WAIT;
                    else              r_d.gap_half = 1'b1;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign cs_n     = ~r_q.cs_on;
    assign busy     = r_q.busy;
    assign rx_valid = r_q.rx_valid;
    assign rx_data  = r_q.rx_data;

    assert_sclk_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> (sclk == CPOL));
    assert_stall_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_CHECK) |-> (sclk == CPOL));
    assert_rx_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));
    assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $rose(cs_n));
    assert_tx_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> (!cs_n && r_q.tx_en));
endmodule

// File: tb/spi_seq_master_test.sv
module spi_seq_master_test;
    localparam logic [1:0] MODE = 2'b11;
    localparam bit   CPOL = MODE[1];
    localparam int   HALF = 2;
    localparam int   CPU  = 10;
    localparam int   NV   = 6;
    // Vector fields: [17:14] len, [13] tx_en, [12] rx_en, [11:8] delay_us, [7:0] first tx byte
    localparam logic [17:0] VEC [NV] = '{
        {4'd2, 1'b1, 1'b1, 4'd1, 8'h81},
        {4'd1, 1'b1, 1'b0, 4'd0, 8'h3C},
        {4'd2, 1'b0, 1'b1, 4'd2, 8'h00},
        {4'd0, 1'b1, 1'b1, 4'd3, 8'h00},
        {4'd3, 1'b1, 1'b1, 4'd0, 8'hF0},
        {4'd0, 1'b0, 1'b0, 4'd0, 8'h00}
    };

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic       rst_n = 1'b0;
    logic       desc_valid = 1'b0, desc_ready;
    logic [3:0] desc_len = '0, desc_delay_us = '0;
    logic       desc_tx_en = 1'b0, desc_rx_en = 1'b0, desc_cs_change = 1'b0, desc_last = 1'b0;
    logic [7:0] tx_data = '0, rx_data;
    logic       tx_valid = 1'b0, tx_ready, rx_valid, rx_ready = 1'b1;
    logic       sclk, mosi, miso, cs_n, busy;

    spi_seq_master #(.MODE(MODE), .HALF_CLKS(HALF), .CLKS_PER_US(CPU), .LEN_W(4), .DLY_W(4)) uut (
        .clk(clk), .rst_n(rst_n), .desc_valid(desc_valid), .desc_ready(desc_ready),
        .desc_len(desc_len), .desc_tx_en(desc_tx_en), .desc_rx_en(desc_rx_en),
        .desc_delay_us(desc_delay_us), .desc_cs_change(desc_cs_change), .desc_last(desc_last),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
        .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n), .busy(busy)
    );

    int checks = 0, errors = 0;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] slave_byte(input int n);
        return 8'(n * 37 + 90);
    endfunction

    // Peripheral model for mode 3: drive on the falling (leading) edge, sample on the rising edge.
    logic       armed = 1'b0;
    int         s_bit = 0, s_done = 0;
    logic [7:0] s_rx = '0;
    logic [7:0] sb_cur;
    logic [7:0] mosi_log [128];
    assign sb_cur = slave_byte(s_done);
    initial miso = 1'b0;

    always @(negedge sclk) if (armed && !cs_n) miso <= sb_cur[3'(7 - s_bit)];
    always @(posedge sclk) if (armed && !cs_n) begin
        s_rx <= {s_rx[6:0], mosi};
        if (s_bit == 7) begin
            mosi_log[s_done % 128] <= {s_rx[6:0], mosi};
            s_done <= s_done + 1;
            s_bit  <= 0;
        end else begin
            s_bit <= s_bit + 1;
        end
    end

    // Monitors sample pre-edge values at the rising clock edge.
    logic [7:0] rx_log [128];
    int rx_cnt = 0, tx_pops = 0, edges = 0, idle_viol = 0, cs_falls = 0, busy_falls = 0;
    int tail = 0, last_tail = 0, hi_run = 0, last_gap = 0;
    logic prev_sclk = 1'b1, prev_cs = 1'b1, prev_busy = 1'b0;
    always @(posedge clk) if (armed) begin
        if (rx_valid && rx_ready) begin
            rx_log[rx_cnt % 128] = rx_data;
            rx_cnt++;
        end
        if (tx_valid && tx_ready) tx_pops++;
        if (sclk != prev_sclk) edges++;
        if (cs_n && sclk != CPOL) idle_viol++;
        if (!cs_n && prev_cs) cs_falls++;
        if (!busy && prev_busy) busy_falls++;
        if (!cs_n) begin
            if (sclk != prev_sclk || prev_cs) tail = 0;
            else tail++;
        end
        if (cs_n && !prev_cs) last_tail = tail;
        if (cs_n && busy) hi_run++;
        if (!cs_n && prev_cs && hi_run > 0) last_gap = hi_run;
        if (!cs_n) hi_run = 0;
        prev_sclk = sclk;
        prev_cs   = cs_n;
        prev_busy = busy;
    end

    task automatic send_desc(input int len, input bit txe, input bit rxe, input int dly,
                             input bit csc, input bit last);
        bit hit;
        desc_len = 4'(len); desc_tx_en = txe; desc_rx_en = rxe;
        desc_delay_us = 4'(dly); desc_cs_change = csc; desc_last = last;
        desc_valid = 1'b1;
        do begin hit = desc_ready; @(negedge clk); end while (!hit);
        desc_valid = 1'b0;
    endtask

    task automatic feed_tx(input logic [7:0] b);
        bit hit;
        tx_data = b; tx_valid = 1'b1;
        do begin hit = tx_ready; @(negedge clk); end while (!hit);
        tx_valid = 1'b0;
    endtask

    task automatic run_xfer(input int len, input bit txe, input bit rxe, input int dly,
                            input bit csc, input bit last, input logic [7:0] base);
        fork
            send_desc(len, txe, rxe, dly, csc, last);
            if (txe) for (int i = 0; i < len; i++) feed_tx(8'(base + i));
        join
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        int s0, r0, e0, p0, c0, b0;
        logic [7:0] held;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(cs_n == 1'b1, "R1", "cs_n in reset", cs_n, 1);
        chk(sclk == CPOL, "R1", "sclk in reset", sclk, CPOL);
        chk(busy == 1'b0 && rx_valid == 1'b0, "R1", "busy|rx_valid in reset", busy | rx_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        armed = 1'b1;
        chk(desc_ready && !tx_ready && cs_n, "R1", "ready after reset", {desc_ready, tx_ready, cs_n}, 3'b101);

        // Table of single-transfer messages
        for (int v = 0; v < NV; v++) begin
            int len, dly;
            bit txe, rxe;
            logic [7:0] base;
            len = int'(VEC[v][17:14]); txe = VEC[v][13]; rxe = VEC[v][12];
            dly = int'(VEC[v][11:8]); base = VEC[v][7:0];
            s0 = s_done; r0 = rx_cnt; e0 = edges; p0 = tx_pops; b0 = busy_falls;
            if (!txe) begin tx_data = 8'h00; tx_valid = 1'b1; end
            run_xfer(len, txe, rxe, dly, 1'b0, 1'b1, base);
            wait_idle();
            tx_valid = 1'b0;
            chk(s_done - s0 == len, "R5", "bytes on wire", s_done - s0, len);
            chk(edges - e0 == 16 * len, "R11", "sclk edges", edges - e0, 16 * len);
            chk(tx_pops - p0 == (txe ? len : 0), "R3", "tx bytes taken", tx_pops - p0, txe ? len : 0);
            for (int i = 0; i < len; i++) begin
                logic [7:0] exp_b;
                exp_b = txe ? 8'(base + i) : 8'hFF;
                chk(mosi_log[(s0 + i) % 128] == exp_b, txe ? "R2" : "R3", "mosi byte",
                    mosi_log[(s0 + i) % 128], exp_b);
            end
            chk(rx_cnt - r0 == (rxe ? len : 0), "R4", "rx bytes pushed", rx_cnt - r0, rxe ? len : 0);
            if (rxe) for (int i = 0; i < len; i++)
                chk(rx_log[(r0 + i) % 128] == slave_byte(s0 + i), "R2", "rx byte",
                    rx_log[(r0 + i) % 128], slave_byte(s0 + i));
            chk(last_tail >= dly * CPU && last_tail <= dly * CPU + 6, "R6", "select hold after last edge",
                last_tail, dly * CPU);
            chk(busy_falls - b0 == 1 && cs_n, "R8", "single release", busy_falls - b0, 1);
        end

        // R7 / R9 / R8: three-transfer message, release only after the second
        c0 = cs_falls; b0 = busy_falls; s0 = s_done;
        run_xfer(1, 1'b1, 1'b0, 0, 1'b0, 1'b0, 8'h11);
        run_xfer(1, 1'b1, 1'b0, 1, 1'b1, 1'b0, 8'h22);
        run_xfer(1, 1'b1, 1'b0, 0, 1'b0, 1'b1, 8'h33);
        wait_idle();
        chk(cs_falls - c0 == 2, "R9", "select assertions in message", cs_falls - c0, 2);
        chk(last_gap >= 2 * HALF, "R7", "deselect gap", last_gap, 2 * HALF);
        chk(busy_falls - b0 == 1, "R8", "busy falls once per message", busy_falls - b0, 1);
        chk(mosi_log[(s0 + 2) % 128] == 8'h33, "R7", "byte after reselect", mosi_log[(s0 + 2) % 128], 8'h33);

        // R10: stall on a missing outgoing byte
        s0 = s_done;
        fork
            send_desc(2, 1'b1, 1'b0, 0, 1'b0, 1'b1);
            feed_tx(8'hA6);
        join
        repeat (60) @(negedge clk);
        e0 = edges;
        repeat (30) @(negedge clk);
        chk(edges == e0, "R10", "edges while stalled", edges - e0, 0);
        chk(sclk == CPOL && !cs_n, "R10", "idle clock, still selected", {sclk, cs_n}, {CPOL, 1'b0});
        feed_tx(8'h5B);
        wait_idle();
        chk(mosi_log[(s0 + 1) % 128] == 8'h5B, "R10", "late byte sent", mosi_log[(s0 + 1) % 128], 8'h5B);

        // R12: receive backpressure
        s0 = s_done; r0 = rx_cnt; e0 = edges;
        rx_ready = 1'b0;
        fork
            begin
                send_desc(2, 1'b1, 1'b1, 0, 1'b0, 1'b1);
                feed_tx(8'h01);
                feed_tx(8'h02);
            end
        join_none
        repeat (100) @(negedge clk);
        chk(rx_valid == 1'b1, "R12", "byte pending", rx_valid, 1);
        chk(edges - e0 == 16, "R12", "no second byte shifted", edges - e0, 16);
        held = rx_data;
        repeat (10) @(negedge clk);
        chk(rx_data == held && rx_valid, "R12", "pending byte stable", rx_data, held);
        chk(held == slave_byte(s0), "R12", "pending byte value", held, slave_byte(s0));
        rx_ready = 1'b1;
        wait fork;
        wait_idle();
        chk(rx_cnt - r0 == 2, "R12", "both bytes delivered", rx_cnt - r0, 2);
        chk(rx_log[(r0 + 1) % 128] == slave_byte(s0 + 1), "R2", "second rx byte",
            rx_log[(r0 + 1) % 128], slave_byte(s0 + 1));

        chk(idle_viol == 0, "R11", "clock moved while deselected", idle_viol, 0);
        finish_run();
    end
endmodule